// File: doc/BRIEF.md
# Buffered Dual-Compare PWM Output Channel

This block is one output channel of a timer. It does not count time itself. It watches an up-counting time base that it shares with other channels and places two edges of a pulse on its output pin. The leading compare value drives the pin to the polarity level. The trailing compare value drives it to the inverse level. Software writes both values into shadow registers. The channel copies them into the active compare registers only when the time base starts a new period, so a period never runs with half-updated values. An update-hold input suspends that copy, so several channels can be reprogrammed and then released together.

Three fixed arbitration rules decide which of two coinciding compare events takes effect. A trailing compare at the same count as the leading compare wins. A leading compare at count zero wins over a trailing edge still pending from the end of the previous period, which makes a 0 % duty cycle possible. Within one period, a leading compare that comes after the trailing compare is ignored.

The channel also has a sticky event flag with a selectable source, two software force strobes, and a mode-entry strobe that loads the pin with the polarity level.

Top module: `dual_cmp_pwm_chan`

## Requirements
- R1: After reset, `pwm_out` and `flag` are 0 and all shadow and active compare values are 0.
- R2: A leading match (time base equals the active leading value) sets `pwm_out` to `pol` at the edge that samples that count. A trailing match sets `pwm_out` to `~pol` one clock later, at the edge that samples the following count.
- R3: `tb_wrap` marks the clock in which the time base is at 0. In that clock, if `upd_hold` is low, the shadow values become active and are already used for the compare at count 0. A shadow write made during a period has no effect before the next such clock.
- R4: While `upd_hold` is high in a `tb_wrap` clock, the active values are kept and the previous waveform repeats.
- R5: If the leading and trailing values match at the same count, only the trailing action happens.
- R6: A leading match at count 0 wins over a trailing action still pending from the last count of the previous period, so leading 0 with trailing at the last count gives a constant `pol` level.
- R7: A leading match at a later count than the trailing match in the same period is ignored.
- R8: With `flag_all` = 0, `flag` is set only by a trailing action, including one that lost to R6. With `flag_all` = 1, a leading match that takes effect also sets it. Pulses continue while `flag` is set.
- R9: `flag` stays set until a clock in which `flag_clr` = 1. If a set and a clear fall in the same clock, the set wins.
- R10: `force_lead` drives `pwm_out` to `pol` and `force_trail` to `~pol` at the next edge, overriding compare actions. If both are given, `force_trail` wins. Neither sets `flag`.
- R11: `mode_enter` loads `pwm_out` with `pol` at the next edge, overriding forces and compare actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one time base count per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_count | input | CNT_W | Selected shared time base value |
| tb_wrap | input | 1 | High in the clock where the time base is at 0 (period start) |
| upd_hold | input | 1 | Blocks the shadow-to-active copy |
| mode_enter | input | 1 | Loads the output with the polarity level |
| pol | input | 1 | Level driven by a leading action |
| flag_all | input | 1 | 1: leading actions also set the flag |
| wr_lead | input | 1 | Write strobe for the leading shadow value |
| lead_val | input | CNT_W | Leading shadow write data |
| wr_trail | input | 1 | Write strobe for the trailing shadow value |
| trail_val | input | CNT_W | Trailing shadow write data |
| force_lead | input | 1 | Force the leading-edge level |
| force_trail | input | 1 | Force the trailing-edge level |
| flag_clr | input | 1 | Clears the flag |
| pwm_out | output | 1 | Channel output pin |
| flag | output | 1 | Sticky event flag |

## Verification
A leading match shows on `pwm_out` one clock after the clock that carried its count. A trailing match shows two clocks after, because its action is held in a one-clock pending stage. Forces, mode entry and flag clears show one clock after their strobe. A flag set shows in the same clock as the output change that caused it. The bench samples one time unit after each rising edge. Before it drives count k, it checks the output against the effect of all counts up to k-1. Its hand-computed patterns and its per-clock reference model are both written in that frame.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

   typedef enum logic [1:0] {
      CMD_KEEP  = 2'd0,
      CMD_LEAD  = 2'd1,
      CMD_TRAIL = 2'd2
   } edge_cmd_e;

   localparam int unsigned SLOT_LEAD  = 0;
   localparam int unsigned SLOT_TRAIL = 1;
   localparam int unsigned N_SLOTS    = 2;

endpackage

// File: rtl/dcp_shadow.sv
module dcp_shadow
   import dcp_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wrap,
   input  logic                            hold,
   input  logic [N_SLOTS-1:0]              wr,
   input  logic [N_SLOTS-1:0][CNT_W-1:0]   wdata,
   output logic [N_SLOTS-1:0][CNT_W-1:0]   shadow,
   output logic [N_SLOTS-1:0][CNT_W-1:0]   active,
   output logic [N_SLOTS-1:0][CNT_W-1:0]   effective
);

   logic load;

   assign load = wrap & ~hold;

   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      logic [CNT_W-1:0] sh_q;
      logic [CNT_W-1:0] act_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q  <= '0;
            act_q <= '0;
         end else begin
            if (load) begin
               act_q <= sh_q;
            end
            if (wr[s]) begin
               sh_q <= wdata[s];
            end
         end
      end

      assign shadow[s]    = sh_q;
      assign active[s]    = act_q;
      assign effective[s] = load ? sh_q : act_q;
   end

endmodule

// File: rtl/dcp_arbiter.sv
module dcp_arbiter
   import dcp_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wrap,
   input  logic [CNT_W-1:0] lead_cmp,
   input  logic [CNT_W-1:0] trail_cmp,
   output edge_cmd_e        cmd,
   output logic             lead_ev,
   output logic             trail_ev
);

   logic lead_hit;
   logic trail_hit;
   logic lead_blocked;
   logic seen_q;
   logic pend_q;

   assign lead_hit  = (cnt == lead_cmp);
   assign trail_hit = (cnt == trail_cmp);

   // blocked by a trailing match at this count or earlier in this period
   assign lead_blocked = trail_hit | (~wrap & seen_q);
   assign lead_ev      = lead_hit & ~lead_blocked;
   assign trail_ev     = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= trail_hit;
         seen_q <= wrap ? trail_hit : (seen_q | trail_hit);
      end
   end

   always_comb begin
      if (lead_ev) begin
         cmd = CMD_LEAD;
      end else if (pend_q) begin
         cmd = CMD_TRAIL;
      end else begin
         cmd = CMD_KEEP;
      end
   end

endmodule

// File: rtl/dcp_outflag.sv
module dcp_outflag
   import dcp_pkg::*;
#(
   parameter bit FORCE_TRAIL_FIRST = 1'b1,
   parameter bit OUT_RST           = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pol,
   input  logic      flag_all,
   input  edge_cmd_e cmd,
   input  logic      lead_ev,
   input  logic      trail_ev,
   input  logic      force_lead,
   input  logic      force_trail,
   input  logic      mode_enter,
   input  logic      flag_clr,
   output logic      pwm_out,
   output logic      flag
);

   logic force_any;
   logic force_lvl;
   logic out_d;
   logic flag_set;

   assign force_any = force_lead | force_trail;

   if (FORCE_TRAIL_FIRST) begin : g_force_trail_first
      assign force_lvl = force_trail ? ~pol : pol;
   end else begin : g_force_lead_first
      assign force_lvl = force_lead ? pol : ~pol;
   end

   always_comb begin
      out_d = pwm_out;
      if (mode_enter) begin
         out_d = pol;
      end else if (force_any) begin
         out_d = force_lvl;
      end else begin
         case (cmd)
            CMD_LEAD:  out_d = pol;
            CMD_TRAIL: out_d = ~pol;
            default:   out_d = pwm_out;
         endcase
      end
   end

   assign flag_set = trail_ev | (flag_all & lead_ev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_out <= OUT_RST;
         flag    <= 1'b0;
      end else begin
         pwm_out <= out_d;
         flag    <= flag_set | (flag & ~flag_clr);
      end
   end

endmodule

// File: rtl/dual_cmp_pwm_chan.sv
module dual_cmp_pwm_chan
   import dcp_pkg::*;
#(
   parameter int unsigned CNT_W             = 16,
   parameter bit          FORCE_TRAIL_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tb_count,
   input  logic             tb_wrap,
   input  logic             upd_hold,
   input  logic             mode_enter,
   input  logic             pol,
   input  logic             flag_all,
   input  logic             wr_lead,
   input  logic [CNT_W-1:0] lead_val,
   input  logic             wr_trail,
   input  logic [CNT_W-1:0] trail_val,
   input  logic             force_lead,
   input  logic             force_trail,
   input  logic             flag_clr,
   output logic             pwm_out,
   output logic             flag
);

   localparam int unsigned CNT_MAX_W = 32;

   if (CNT_W < 2 || CNT_W > CNT_MAX_W) begin : g_bad_width
      $error("dual_cmp_pwm_chan: CNT_W out of range");
   end

   logic [N_SLOTS-1:0]            wr_v;
   logic [N_SLOTS-1:0][CNT_W-1:0] wdata_v;
   logic [N_SLOTS-1:0][CNT_W-1:0] sh_v;
   logic [N_SLOTS-1:0][CNT_W-1:0] act_v;
   logic [N_SLOTS-1:0][CNT_W-1:0] eff_v;
   logic [CNT_W-1:0]              lead_sh;
   logic [CNT_W-1:0]              lead_act;
   logic [CNT_W-1:0]              trail_sh;
   logic [CNT_W-1:0]              trail_act;
   edge_cmd_e                     cmd;
   logic                          lead_ev;
   logic                          trail_ev;

   assign wr_v[SLOT_LEAD]     = wr_lead;
   assign wr_v[SLOT_TRAIL]    = wr_trail;
   assign wdata_v[SLOT_LEAD]  = lead_val;
   assign wdata_v[SLOT_TRAIL] = trail_val;

   assign lead_sh   = sh_v[SLOT_LEAD];
   assign trail_sh  = sh_v[SLOT_TRAIL];
   assign lead_act  = act_v[SLOT_LEAD];
   assign trail_act = act_v[SLOT_TRAIL];

   dcp_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .wrap      (tb_wrap),
      .hold      (upd_hold),
      .wr        (wr_v),
      .wdata     (wdata_v),
      .shadow    (sh_v),
      .active    (act_v),
      .effective (eff_v)
   );

   dcp_arbiter #(.CNT_W(CNT_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (tb_count),
      .wrap      (tb_wrap),
      .lead_cmp  (eff_v[SLOT_LEAD]),
      .trail_cmp (eff_v[SLOT_TRAIL]),
      .cmd       (cmd),
      .lead_ev   (lead_ev),
      .trail_ev  (trail_ev)
   );

   dcp_outflag #(
      .FORCE_TRAIL_FIRST (FORCE_TRAIL_FIRST),
      .OUT_RST           (1'b0)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .pol         (pol),
      .flag_all    (flag_all),
      .cmd         (cmd),
      .lead_ev     (lead_ev),
      .trail_ev    (trail_ev),
      .force_lead  (force_lead),
      .force_trail (force_trail),
      .mode_enter  (mode_enter),
      .flag_clr    (flag_clr),
      .pwm_out     (pwm_out),
      .flag        (flag)
   );

endmodule

// File: rtl/dcp_chk.sv
module dcp_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tb_wrap,
   input logic             upd_hold,
   input logic             mode_enter,
   input logic             pol,
   input logic             force_lead,
   input logic             force_trail,
   input logic             flag_clr,
   input logic             pwm_out,
   input logic             flag,
   input logic [CNT_W-1:0] lead_sh,
   input logic [CNT_W-1:0] lead_act,
   input logic [CNT_W-1:0] trail_sh,
   input logic [CNT_W-1:0] trail_act
);

   // R11
   mode_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_enter |=> pwm_out == $past(pol));

   // R10
   force_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_lead && !force_trail && !mode_enter |=> pwm_out == $past(pol));

   // R10
   force_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_trail && !force_lead && !mode_enter |=> pwm_out != $past(pol));

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !flag_clr |=> flag);

   // R3
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tb_wrap && !upd_hold |=> lead_act == $past(lead_sh) && trail_act == $past(trail_sh));

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_hold |=> $stable(lead_act) && $stable(trail_act));

endmodule

bind dual_cmp_pwm_chan dcp_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tb_wrap     (tb_wrap),
   .upd_hold    (upd_hold),
   .mode_enter  (mode_enter),
   .pol         (pol),
   .force_lead  (force_lead),
   .force_trail (force_trail),
   .flag_clr    (flag_clr),
   .pwm_out     (pwm_out),
   .flag        (flag),
   .lead_sh     (lead_sh),
   .lead_act    (lead_act),
   .trail_sh    (trail_sh),
   .trail_act   (trail_act)
);

// File: tb/test_dual_cmp_pwm_chan.sv
`timescale 1ns/100ps
module test_dual_cmp_pwm_chan;

   localparam int W   = 4;
   localparam int PER = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cnt = '0;
   logic         wrap = 1'b1;
   logic         hold = 1'b0, menter = 1'b0, pol = 1'b0, fall = 1'b0;
   logic         wa = 1'b0, wb = 1'b0, fa = 1'b0, fb = 1'b0, fclr = 1'b0;
   logic [W-1:0] va = '0, vb = '0;
   logic         pwm_out, flag;

   int checks = 0;
   int fails  = 0;
   int cur    = 0;
   bit done   = 1'b0;

   logic [W-1:0] m_a1 = '0, m_b1 = '0, m_a2 = '0, m_b2 = '0;
   logic         m_out = 1'b0, m_flag = 1'b0, m_pend = 1'b0, m_seen = 1'b0;

   always #2.5 clk = ~clk;

   dual_cmp_pwm_chan #(.CNT_W(W)) i_dual_cmp_pwm_chan (
      .clk(clk), .rst_n(rst_n), .tb_count(cnt), .tb_wrap(wrap), .upd_hold(hold),
      .mode_enter(menter), .pol(pol), .flag_all(fall),
      .wr_lead(wa), .lead_val(va), .wr_trail(wb), .trail_val(vb),
      .force_lead(fa), .force_trail(fb), .flag_clr(fclr),
      .pwm_out(pwm_out), .flag(flag)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at count %0d: got %0b expected %0b", tag, cur, act, exp);
      end
   endtask

   // reference model of one clock, written from the requirements
   task automatic model_step();
      logic ld, bh, ah, aev;
      logic [W-1:0] ea, eb;
      ld = wrap && !hold;
      ea = ld ? m_a2 : m_a1;
      eb = ld ? m_b2 : m_b1;
      bh = (cnt == eb);
      ah = (cnt == ea);
      aev = ah && !(bh || (!wrap && m_seen));
      if (menter)      m_out = pol;
      else if (fb)     m_out = !pol;
      else if (fa)     m_out = pol;
      else if (aev)    m_out = pol;
      else if (m_pend) m_out = !pol;
      m_flag = m_pend || (fall && aev) || (m_flag && !fclr);
      m_seen = wrap ? bh : (m_seen || bh);
      m_pend = bh;
      if (ld) begin m_a1 = m_a2; m_b1 = m_b2; end
      if (wa) m_a2 = va;
      if (wb) m_b2 = vb;
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      #1;
      wa = 0; wb = 0; fa = 0; fb = 0; fclr = 0; menter = 0;
      cur  = (cur + 1) % PER;
      cnt  = W'(cur);
      wrap = (cur == 0);
   endtask

   task automatic to_zero();
      while (cur != 0) tick();
   endtask

   task automatic load_pair(input int a, input int b);
      wa = 1; va = W'(a); wb = 1; vb = W'(b);
      tick();
      to_zero();
   endtask

   task automatic chk_cycle(input logic [7:0] pat, input string tag);
      for (int k = 0; k < PER; k++) begin
         chk(pwm_out, pat[k], tag);
         tick();
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1 reset state
      chk(pwm_out, 1'b0, "R1 out");
      chk(flag, 1'b0, "R1 flag");

      // R2: lead 2 -> low seen from count 3, trail 5 -> high seen from count 7
      load_pair(2, 5);
      for (int k = 0; k < PER; k++) begin
         chk(pwm_out, (k >= 3 && k <= 6) ? 1'b0 : 1'b1, "R2");
         if (k == 1) begin wa = 1; va = 4; wb = 1; vb = 6; end
         tick();
      end
      // R3: the mid-period write takes effect only from this period
      chk_cycle(8'b0001_1111, "R3");
      // R4: hold keeps lead 4 / trail 6 across a boundary
      hold = 1; wa = 1; va = 1; wb = 1; vb = 3;
      tick();
      to_zero();
      chk_cycle(8'b0001_1111, "R4 hold");
      hold = 0;
      chk_cycle(8'b1110_0011, "R4 release");
      // R5: tie at count 3, trailing wins
      load_pair(3, 3);
      chk_cycle(8'hFF, "R5");
      // R7: lead after trail is ignored
      load_pair(5, 2);
      chk_cycle(8'hFF, "R7");
      // R6: lead 0 beats the trailing action left from count 7
      load_pair(0, 7);
      tick();
      to_zero();
      chk_cycle(8'h00, "R6");

      // R8 / R9 flag behaviour with lead 2, trail 5
      load_pair(2, 5);
      tick();
      to_zero();
      fclr = 1;
      tick();
      chk(flag, 1'b0, "R9 clear");
      while (cur != 3) tick();
      chk(flag, 1'b0, "R8 lead does not set flag");
      while (cur != 7) tick();
      chk(flag, 1'b1, "R8 trail sets flag");
      tick();
      chk(flag, 1'b1, "R9 sticky");
      fclr = 1;
      tick();
      while (cur != 6) tick();
      chk(flag, 1'b0, "R9 cleared before set");
      fclr = 1;
      tick();
      chk(flag, 1'b1, "R9 set wins over clear");
      to_zero();
      fall = 1; fclr = 1;
      tick();
      while (cur != 3) tick();
      chk(flag, 1'b1, "R8 lead sets flag in all-edge mode");
      to_zero();

      // R10 forces
      fall = 0; fclr = 1; fa = 1;
      tick();
      chk(pwm_out, 1'b0, "R10 force lead");
      while (cur != 3) tick();
      fb = 1;
      tick();
      chk(pwm_out, 1'b1, "R10 force trail");
      chk(flag, 1'b0, "R10 force leaves flag");
      // R11 mode entry
      menter = 1;
      tick();
      chk(pwm_out, 1'b0, "R11 pol 0");
      pol = 1; menter = 1;
      tick();
      chk(pwm_out, 1'b1, "R11 pol 1");
      fa = 1; fb = 1;
      tick();
      chk(pwm_out, 1'b0, "R10 both forces");
      pol = 0;

      // sweep against the reference model
      for (int p = 0; p < 2; p++) begin
         for (int fm = 0; fm < 2; fm++) begin
            for (int a = 0; a <= PER; a++) begin
               for (int b = 0; b <= PER; b++) begin
                  while (cur != 4) begin
                     chk(pwm_out, m_out, "R2/R3 sweep out");
                     chk(flag, m_flag, "R8/R9 sweep flag");
                     tick();
                  end
                  pol = p[0]; fall = fm[0];
                  wa = 1; va = W'(a); wb = 1; vb = W'(b);
                  for (int i = 0; i < 2 * PER; i++) begin
                     chk(pwm_out, m_out, "R2/R3 sweep out");
                     chk(flag, m_flag, "R8/R9 sweep flag");
                     if (cur == 1) fclr = 1;
                     tick();
                  end
               end
            end
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule